// File: doc/BRIEF.md
# Timer Channel Interrupt Delivery

This block is a single channel of a multi-channel event timer. It holds the channel's configuration word, its 64-bit comparator and its 64-bit message route. Software reaches all three as 32-bit halves over a simple register bus. Matching and reload logic sit elsewhere. They drive the channel's `ev_set` and `ev_clr` strobes, and the block then decides how the event is delivered.

An event can be delivered in one of two ways. The first is a legacy interrupt line, picked from 32 outputs by a route field. It is held high in level mode and pulsed for one cycle in edge mode. The second is a message: a single 32-bit memory write on a valid/ready master port. The data is the low half of the route register and the address is the high half. Message delivery exists only when the `MSG_CAPABLE` parameter is set at elaboration. That parameter defaults to off.

Top module: `tmr_chan_deliver`

## Requirements
- R1: After reset, the configuration low word reads 0x0000_0030, with bit 15 set when MSG_CAPABLE=1. The high word reads the ROUTE_CAP parameter, whose default 0x4 sets bit 34. Both comparator words read 0xFFFF_FFFF and both route words read 0.
- R2: Word addresses are 0 cfg-low, 1 cfg-high (read-only), 2 cmp-low, 3 cmp-high, 4 route-low (message data) and 5 route-high (message address). A write to one half leaves the other half unchanged, and each read returns the matching half.
- R3: Message mode is cfg bit 14 = 1. In message mode, an `ev_set` while the channel is active (cfg bit 2 and `glb_en` both high) starts one write with `msg_addr` = route[63:32] and `msg_data` = route[31:0]. The status bit and the legacy lines stay unchanged.
- R4: `msg_valid` stays high with stable `msg_addr`/`msg_data` until a cycle with `msg_ready` high. It falls in the cycle after that handshake.
- R5: An `ev_set` that arrives while a write is still waiting is merged into that write. No second write is queued, and the pending address and data are kept.
- R6: Level mode is cfg bit 1 = 1, with message mode off. In level mode, an `ev_set` on an active channel sets `level_status` and raises `irq_lines[route]`, where route is cfg bits 13:9.
- R7: In edge mode (cfg bit 1 = 0), an `ev_set` on an active channel drives `irq_lines[route]` high for exactly one cycle and leaves `level_status` at 0.
- R8: A deassert clears `level_status` and lowers the level line. A deassert is either `ev_clr`, or `ev_set` while the timer enable or `glb_en` is low.
- R9: A configuration write that changes bit 14 from 0 to 1 first clears any pending status, so the level line drops.
- R10: A configuration write whose route field names a line not set in ROUTE_CAP leaves the stored route unchanged. The other fields of that write still take effect.
- R11: When MSG_CAPABLE=0, cfg bit 14 always reads 0 and an `ev_set` never starts a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | 32-bit word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| glb_en | input | 1 | Global timer enable |
| ev_set | input | 1 | Interrupt assert strobe |
| ev_clr | input | 1 | Interrupt deassert strobe |
| level_status | output | 1 | Level-mode status bit |
| irq_lines | output | 32 | Legacy interrupt outputs |
| msg_valid | output | 1 | Message write request |
| msg_ready | input | 1 | Message write accepted |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
Register writes, strobes and handshakes each take effect at the first rising edge after they are presented. `reg_rdata` follows `reg_addr` combinationally. The bench drives inputs on falling edges and reads results at the next falling edge, half a period after the edge that updated them. An edge-mode pulse is checked at that falling edge and checked again as low one falling edge later. A pending message is checked across a stalled cycle before `msg_ready` is raised. The route field is swept over all 32 values, and the readback after each write is compared with a value tracked from ROUTE_CAP.

// File: rtl/tmr_chan_deliver.sv
module tmr_chan_deliver #(
  parameter bit          MSG_CAPABLE = 1'b0,
  parameter logic [31:0] ROUTE_CAP   = 32'h0000_0004
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_en,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        glb_en,
  input  logic        ev_set,
  input  logic        ev_clr,
  output logic        level_status,
  output logic [31:0] irq_lines,
  output logic        msg_valid,
  input  logic        msg_ready,
  output logic [31:0] msg_addr,
  output logic [31:0] msg_data
);

  logic        lvl_mode, tmr_en, msg_en, pulse_q, sts_q;
  logic [4:0]  route;
  logic [63:0] cmp, rt;
  logic [31:0] m_addr, m_data;
  logic        m_valid;

  wire        wr      = reg_en & reg_we;
  wire        wr_cfg  = wr && reg_addr == 3'd0;
  wire        active  = glb_en & tmr_en;
  wire        msg_rise = wr_cfg & MSG_CAPABLE & reg_wdata[14] & ~msg_en;
  wire        deassert = ev_clr | (ev_set & ~active);
  wire [31:0] cfg_lo = {16'b0, MSG_CAPABLE, msg_en, route, 3'b0, 1'b1, 1'b1,
                        1'b0, tmr_en, lvl_mode, 1'b0};

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = cfg_lo;
      3'd1:    reg_rdata = ROUTE_CAP;
      3'd2:    reg_rdata = cmp[31:0];
      3'd3:    reg_rdata = cmp[63:32];
      3'd4:    reg_rdata = rt[31:0];
      3'd5:    reg_rdata = rt[63:32];
      default: reg_rdata = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_mode <= 1'b0;
      tmr_en   <= 1'b0;
      msg_en   <= 1'b0;
      route    <= 5'd0;
      cmp      <= '1;
      rt       <= '0;
      sts_q    <= 1'b0;
      pulse_q  <= 1'b0;
      m_valid  <= 1'b0;
      m_addr   <= '0;
      m_data   <= '0;
    end else begin
      pulse_q <= 1'b0;
      if (m_valid && msg_ready) m_valid <= 1'b0;
      if (wr) begin
        case (reg_addr)
          3'd0: begin
            lvl_mode <= reg_wdata[1];
            tmr_en   <= reg_wdata[2];
            msg_en   <= MSG_CAPABLE & reg_wdata[14];
            if (ROUTE_CAP[reg_wdata[13:9]]) route <= reg_wdata[13:9];
          end
          3'd2: cmp[31:0]  <= reg_wdata;
          3'd3: cmp[63:32] <= reg_wdata;
          3'd4: rt[31:0]   <= reg_wdata;
          3'd5: rt[63:32]  <= reg_wdata;
          default: ;
        endcase
      end
      if (msg_rise || deassert) begin
        sts_q <= 1'b0;
      end else if (ev_set) begin
        if (msg_en) begin
          if (!m_valid || msg_ready) begin
            m_valid <= 1'b1;
            m_addr  <= rt[63:32];
            m_data  <= rt[31:0];
          end
        end else if (lvl_mode) begin
          sts_q <= 1'b1;
        end else begin
          pulse_q <= 1'b1;
        end
      end
    end
  end

  assign level_status = sts_q;
  assign irq_lines    = ((sts_q & ~msg_en) | pulse_q) ? (32'h1 << route) : 32'h0;
  assign msg_valid    = m_valid;
  assign msg_addr     = m_addr;
  assign msg_data     = m_data;

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));
  assert_one_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_lines));
  assert_no_status_in_msg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_set && msg_en && !msg_rise |=> !level_status || $past(level_status));
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clr |=> !level_status);
  assert_no_msg_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !MSG_CAPABLE |-> !msg_valid && !reg_rdata[14] || reg_addr != 3'd0);

endmodule

// File: tb/sim_tmr_chan_deliver.sv
module sim_tmr_chan_deliver;
  logic clk = 0;
  always #2 clk = ~clk;

  logic        rst_n, reg_en0, reg_en1, reg_we, glb_en, ev_set, ev_clr, msg_ready;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] rd0, rd1, lines0, lines1, ma0, md0, ma1, md1;
  logic        st0, st1, mv0, mv1;
  int checks = 0, errors = 0, accepted = 0;
  localparam logic [31:0] CAP0 = 32'h0000_00F4;

  tmr_chan_deliver #(.MSG_CAPABLE(1'b1), .ROUTE_CAP(CAP0)) u0 (
    .clk, .rst_n, .reg_en(reg_en0), .reg_we, .reg_addr, .reg_wdata, .reg_rdata(rd0),
    .glb_en, .ev_set, .ev_clr, .level_status(st0), .irq_lines(lines0),
    .msg_valid(mv0), .msg_ready, .msg_addr(ma0), .msg_data(md0));
  tmr_chan_deliver u1 (
    .clk, .rst_n, .reg_en(reg_en1), .reg_we, .reg_addr, .reg_wdata, .reg_rdata(rd1),
    .glb_en, .ev_set, .ev_clr, .level_status(st1), .irq_lines(lines1),
    .msg_valid(mv1), .msg_ready, .msg_addr(ma1), .msg_data(md1));

  always @(posedge clk) if (rst_n && mv0 && msg_ready) accepted++;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(bit which, logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_en0 = !which; reg_en1 = which; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en0 = 0; reg_en1 = 0; reg_we = 0;
  endtask

  task automatic rd(logic [2:0] a);
    reg_addr = a; #1;
  endtask

  task automatic strobe(bit set);
    @(negedge clk);
    if (set) ev_set = 1; else ev_clr = 1;
    @(negedge clk);
    ev_set = 0; ev_clr = 0;
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [4:0] exp_route;
    rst_n = 0; reg_en0 = 0; reg_en1 = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    glb_en = 0; ev_set = 0; ev_clr = 0; msg_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values
    rd(0); chk("R1 cfg lo u0", rd0, 32'h0000_8030); chk("R1 cfg lo u1", rd1, 32'h0000_0030);
    rd(1); chk("R1 cfg hi u0", rd0, CAP0); chk("R1 cfg hi u1 bit34", rd1, 32'h4);
    rd(2); chk("R1 cmp lo", rd0, 32'hFFFF_FFFF);
    rd(3); chk("R1 cmp hi", rd0, 32'hFFFF_FFFF);
    rd(4); chk("R1 route lo", rd0, 0);
    rd(5); chk("R1 route hi", rd0, 0);
    // R2 halves
    wr(0, 2, 32'h1111_2222);
    rd(2); chk("R2 cmp lo", rd0, 32'h1111_2222);
    rd(3); chk("R2 cmp hi kept", rd0, 32'hFFFF_FFFF);
    wr(0, 5, 32'hA000_0000); wr(0, 4, 32'h55);
    rd(5); chk("R2 route hi", rd0, 32'hA000_0000);
    rd(4); chk("R2 route lo", rd0, 32'h55);
    wr(0, 1, 32'hDEAD_BEEF);
    rd(1); chk("R2 cfg hi read-only", rd0, CAP0);
    // R10 route sweep
    exp_route = 0;
    for (int r = 0; r < 32; r++) begin
      wr(0, 0, (32'(r) << 9) | 32'h6);
      if (CAP0[r]) exp_route = 5'(r);
      rd(0); chk("R10 route field", (rd0 >> 9) & 32'h1F, 32'(exp_route));
      chk("R10 other fields", rd0 & 32'h6, 32'h6);
    end
    // R6 / R8 level mode on each advertised line
    glb_en = 1;
    for (int r = 0; r < 32; r++) begin
      if (CAP0[r]) begin
        wr(0, 0, (32'(r) << 9) | 32'h6);
        strobe(1);
        chk("R6 status set", 32'(st0), 1);
        chk("R6 line raised", lines0, 32'h1 << r);
        strobe(0);
        chk("R8 status cleared", 32'(st0), 0);
        chk("R8 line lowered", lines0, 0);
      end
    end
    // R7 edge pulse
    wr(0, 0, (32'd5 << 9) | 32'h4);
    strobe(1);
    chk("R7 pulse high", lines0, 32'h20);
    chk("R7 no status", 32'(st0), 0);
    @(negedge clk);
    chk("R7 pulse one cycle", lines0, 0);
    // R8 deassert via disabled global
    wr(0, 0, (32'd2 << 9) | 32'h6);
    strobe(1);
    chk("R8 precondition", 32'(st0), 1);
    glb_en = 0;
    strobe(1);
    chk("R8 set while disabled clears", 32'(st0), 0);
    chk("R8 line low when disabled", lines0, 0);
    glb_en = 1;
    // R9 enabling message mode clears pending
    strobe(1);
    chk("R9 precondition", lines0, 32'h4);
    wr(0, 0, 32'h4000 | (32'd2 << 9) | 32'h6);
    chk("R9 status cleared", 32'(st0), 0);
    chk("R9 line lowered", lines0, 0);
    rd(0); chk("R9 msg enable stored", rd0 & 32'h4000, 32'h4000);
    // R3 message write
    wr(0, 5, 32'hFEE0_0000); wr(0, 4, 32'h41);
    strobe(1);
    chk("R3 valid", 32'(mv0), 1);
    chk("R3 addr", ma0, 32'hFEE0_0000);
    chk("R3 data", md0, 32'h41);
    chk("R3 no status", 32'(st0), 0);
    chk("R3 no line", lines0, 0);
    // R5 coalesce
    wr(0, 4, 32'h99);
    strobe(1);
    chk("R5 data kept", md0, 32'h41);
    // R4 handshake
    @(negedge clk);
    chk("R4 still valid", 32'(mv0), 1);
    msg_ready = 1;
    @(negedge clk);
    msg_ready = 0;
    chk("R4 valid drops", 32'(mv0), 0);
    chk("R5 single write", 32'(accepted), 1);
    strobe(1);
    chk("R3 new data latched", md0, 32'h99);
    msg_ready = 1;
    @(negedge clk);
    msg_ready = 0;
    chk("R4 second write", 32'(accepted), 2);
    // R11 no message capability
    wr(1, 0, 32'h4000 | (32'd2 << 9) | 32'h4);
    rd(0); chk("R11 msg enable reads zero", rd1 & 32'h4000, 0);
    strobe(1);
    chk("R11 no write", 32'(mv1), 0);
    chk("R11 legacy pulse instead", lines1, 32'h4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule